// File: doc/BRIEF.md
# Cascaded Millisecond, User-Period and Seconds Tick Generator

This block turns a free-running clock of known frequency into three single-cycle strobes for timing logic elsewhere on the chip. A base counter divides the clock down to one strobe per millisecond. Two further counters count those millisecond strobes: one fires after a configurable number of milliseconds, and the other fires after one thousand milliseconds. The seconds counter can be left out when the block is elaborated.

Every period is fixed when the block is elaborated. A simulation divisor shortens the base millisecond period so that a test reaches user and seconds events within a practical number of cycles. The periods of the derived strobes, counted in millisecond strobes, do not change with the divisor. The reset input is active-high by default and can be made active-low. It can be synchronous or asynchronous. A system that needs no reset ties it to its inactive level.

Top module: `tick_gen`

## Requirements
- R1: `tick_ms` is high for exactly one cycle and repeats every MS_CYC cycles, where MS_CYC = max(1, CLK_HZ / 1000 / SIM_DIV).
- R2: After reset is released, `tick_ms` is first high in the cycle that follows the MS_CYC-th rising edge at which reset is sampled inactive.
- R3: `tick_user` is high in every USER_MS-th `tick_ms` cycle counted from reset, so the first one comes with the USER_MS-th `tick_ms`.
- R4: With SEC_EN = 1, `tick_sec` is high in every 1000th `tick_ms` cycle counted from reset. With SEC_EN = 0, `tick_sec` stays 0.
- R5: SIM_DIV shortens only the base period. The user and seconds periods keep the same number of `tick_ms` strobes.
- R6: `tick_user` and `tick_sec` are never high in a cycle where `tick_ms` is low.
- R7: While reset is active, all three outputs are 0 and all counters restart. Releasing reset in the middle of a run restarts the timing exactly as in R2.
- R8: RST_LOW = 1 makes `rst_i` active-low. RST_ASYNC = 1 clears the counters and the outputs as soon as reset asserts, without waiting for a clock edge. With RST_ASYNC = 0, the clear takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_i | input | 1 | Reset; polarity set by RST_LOW, synchronous or asynchronous set by RST_ASYNC |
| tick_ms | output | 1 | One-cycle strobe each (scaled) millisecond |
| tick_user | output | 1 | One-cycle strobe every USER_MS milliseconds |
| tick_sec | output | 1 | One-cycle strobe every 1000 milliseconds, or 0 when SEC_EN = 0 |

## Verification
Every strobe comes out of a register. For a tick that is due N cycles after reset release, the output is high in the cycle after the N-th rising edge. The bench counts rising edges from the release and samples each output on the falling edge that follows that count. Its table lists cycle numbers just before, on and just after each expected strobe, so a tick that arrives one cycle early or one cycle late is caught. For the asynchronous variant, the bench checks the outputs a moment after reset asserts and before the next edge. It checks the synchronous instance at the same moment and expects its strobe to be still high.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // Counter width for a modulus n, never below one bit.
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
  // Clamp a period to at least one cycle.
  function automatic int unsigned at_least_one(input int unsigned n);
    return (n < 1) ? 1 : n;
  endfunction
endpackage

// File: rtl/tick_stage.sv
module tick_stage
  import tick_pkg::*;
#(
  parameter int unsigned PERIOD    = 10,
  parameter bit          RST_LOW   = 1'b0,
  parameter bit          RST_ASYNC = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic adv_i,   // count enable, one cycle ahead of the lower tick
  output logic wrap_o,  // this stage wraps at the next edge
  output logic tick_o   // registered strobe
);
  localparam int unsigned W = cnt_w(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic         rst_act;
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nx;

  assign rst_act = RST_LOW ? ~rst_i : rst_i;
  assign wrap_o  = adv_i && (cnt == LAST);

  always_comb begin
    cnt_nx = cnt;
    if (adv_i) cnt_nx = (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  generate
    if (RST_ASYNC) begin : g_arst
      always_ff @(posedge clk_i or posedge rst_act) begin
        if (rst_act) begin
          cnt    <= '0;
          tick_o <= 1'b0;
        end else begin
          cnt    <= cnt_nx;
          tick_o <= wrap_o;
        end
      end
    end else begin : g_srst
      always_ff @(posedge clk_i) begin
        if (rst_act) begin
          cnt    <= '0;
          tick_o <= 1'b0;
        end else begin
          cnt    <= cnt_nx;
          tick_o <= wrap_o;
        end
      end
    end
  endgenerate

  // R1: the counter never runs past its modulus
  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (rst_act)
    cnt <= LAST);
  // R6: a derived counter moves only when the lower level wraps
  p_hold_r6: assert property (@(posedge clk_i) disable iff (rst_act)
    !adv_i |=> $stable(cnt));
  // R7: reset leaves this stage's strobe low
  p_rst_quiet_r7: assert property (@(posedge clk_i)
    rst_act |=> !tick_o);
endmodule

// File: rtl/tick_gen.sv
module tick_gen
  import tick_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned USER_MS   = 16,
  parameter bit          SEC_EN    = 1'b1,
  parameter int unsigned SIM_DIV   = 1,
  parameter bit          RST_LOW   = 1'b0,
  parameter bit          RST_ASYNC = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_ms,
  output logic tick_user,
  output logic tick_sec
);
  localparam int unsigned MS_CYC  = at_least_one(CLK_HZ / 1000 / at_least_one(SIM_DIV));
  localparam int unsigned USR_CNT = at_least_one(USER_MS);
  localparam int unsigned SEC_CNT = 1000;

  logic rst_act;
  logic ms_wrap;
  logic usr_wrap;

  assign rst_act = RST_LOW ? ~rst_i : rst_i;

  tick_stage #(.PERIOD(MS_CYC), .RST_LOW(RST_LOW), .RST_ASYNC(RST_ASYNC)) u_ms (
    .clk_i(clk_i), .rst_i(rst_i), .adv_i(1'b1), .wrap_o(ms_wrap), .tick_o(tick_ms));

  tick_stage #(.PERIOD(USR_CNT), .RST_LOW(RST_LOW), .RST_ASYNC(RST_ASYNC)) u_usr (
    .clk_i(clk_i), .rst_i(rst_i), .adv_i(ms_wrap), .wrap_o(usr_wrap), .tick_o(tick_user));

  generate
    if (SEC_EN) begin : g_sec
      logic sec_wrap;
      tick_stage #(.PERIOD(SEC_CNT), .RST_LOW(RST_LOW), .RST_ASYNC(RST_ASYNC)) u_sec (
        .clk_i(clk_i), .rst_i(rst_i), .adv_i(ms_wrap), .wrap_o(sec_wrap), .tick_o(tick_sec));
    end else begin : g_nosec
      assign tick_sec = 1'b0;
    end
  endgenerate

  // R6: derived strobes only ride on a millisecond strobe
  p_user_in_ms_r6: assert property (@(posedge clk_i) disable iff (rst_act)
    tick_user |-> tick_ms);
  p_sec_in_ms_r6: assert property (@(posedge clk_i) disable iff (rst_act)
    tick_sec |-> tick_ms);

  // R1: a millisecond strobe lasts one cycle when the period exceeds one
  generate
    if (MS_CYC > 1) begin : g_ms_single
      p_ms_single_r1: assert property (@(posedge clk_i) disable iff (rst_act)
        tick_ms |=> !tick_ms);
    end
  endgenerate
endmodule

// File: tb/tick_gen_bench.sv
`timescale 1ns/1ps
module tick_gen_bench;
  localparam int unsigned CLK_HZ  = 50_000_000;
  localparam int unsigned SIM_DIV = 5000;   // base period 10 cycles
  localparam int unsigned MS_P    = 10;
  localparam int unsigned USER_MS = 4;
  localparam int unsigned VEC_N   = 12;

  // cycle after release, expected {ms,user,sec}
  localparam int unsigned VEC_CYC [VEC_N] =
    '{9, 10, 11, 20, 39, 40, 41, 80, 9990, 10000, 10001, 20000};
  localparam logic [2:0] VEC_EXP [VEC_N] =
    '{3'b000, 3'b100, 3'b000, 3'b100, 3'b000, 3'b110, 3'b000, 3'b110,
      3'b100, 3'b111, 3'b000, 3'b111};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_n;
  logic ms_a, usr_a, sec_a;
  logic ms_b, usr_b, sec_b;
  int   total = 0;
  int   bad = 0;
  int unsigned cur = 0;

  always #10 clk = ~clk;
  assign rst_n = ~rst;

  tick_gen #(.CLK_HZ(CLK_HZ), .USER_MS(USER_MS), .SEC_EN(1'b1), .SIM_DIV(SIM_DIV),
             .RST_LOW(1'b0), .RST_ASYNC(1'b0)) u_tick_gen (
    .clk_i(clk), .rst_i(rst), .tick_ms(ms_a), .tick_user(usr_a), .tick_sec(sec_a));

  // variant: active-low asynchronous reset, user period 1, no seconds
  tick_gen #(.CLK_HZ(CLK_HZ), .USER_MS(1), .SEC_EN(1'b0), .SIM_DIV(SIM_DIV),
             .RST_LOW(1'b1), .RST_ASYNC(1'b1)) u_tick_gen_alt (
    .clk_i(clk), .rst_i(rst_n), .tick_ms(ms_b), .tick_user(usr_b), .tick_sec(sec_b));

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cur, act, exp);
    end
  endtask

  task automatic goto_cycle(input int unsigned n);
    repeat (n - cur) @(posedge clk);
    @(negedge clk);
    cur = n;
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst = 1'b0;
    cur = 0;
  endtask

  initial begin
    #5_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R7: outputs quiet while reset is held
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R7 ms in reset", ms_a, 1'b0);
    check("R7 user in reset", usr_a, 1'b0);
    check("R7 sec in reset", sec_a, 1'b0);
    check("R7 alt ms in reset", ms_b, 1'b0);
    release_rst();

    // table walk: R1, R2, R3, R4, R5 on main; R4, R8 on variant
    for (int i = 0; i < VEC_N; i++) begin
      goto_cycle(VEC_CYC[i]);
      check("R1/R2/R5 tick_ms", ms_a, VEC_EXP[i][2]);
      check("R3 tick_user", usr_a, VEC_EXP[i][1]);
      check("R4 tick_sec", sec_a, VEC_EXP[i][0]);
      check("R8 alt tick_ms", ms_b, VEC_EXP[i][2]);
      check("R3 alt user period 1", usr_b, VEC_EXP[i][2]);
      check("R4 alt seconds off", sec_b, 1'b0);
    end

    // R8: at cycle 20000 both strobes are high; assert reset off-edge
    rst = 1'b1;
    #1;
    check("R8 async clears at once", ms_b, 1'b0);
    check("R8 sync waits for edge", ms_a, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R7 sync cleared after edge", ms_a, 1'b0);
    check("R6 user low in reset", usr_a, 1'b0);
    repeat (2) @(posedge clk);

    // R7/R2: mid-run reset restarts timing from zero
    release_rst();
    goto_cycle(MS_P - 1);
    check("R2 no early tick after restart", ms_a, 1'b0);
    check("R2 alt no early tick", ms_b, 1'b0);
    goto_cycle(MS_P);
    check("R2 first tick after restart", ms_a, 1'b1);
    check("R7 user counter restarted", usr_a, 1'b0);
    check("R2 alt first tick", ms_b, 1'b1);
    goto_cycle(MS_P * USER_MS);
    check("R3 user after restart", usr_a, 1'b1);
    check("R6 ms with user", ms_a, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule